// File: doc/BRIEF.md
# Scan-Line DMA Slot Scheduler

This block sequences three list-driven sound DMA channels inside each video scan line. Each channel keeps a 16-bit RAM pointer to a list of 16-bit commands. A rising edge on the horizontal sync input starts a fixed run of 1 us slots. First comes an idle (dead) slot. Next, each active channel gets one fetch slot, in which its command is read from RAM. Last, each active channel gets one execute slot, in which the fetched command is presented for execution. A LOAD command holds its execute slot for at least eight slot periods, because it drives the shared parallel peripheral that also reaches the sound generator.

The slot period comes from an external one-clock strobe (`slot_tick`), one pulse per microsecond. The memory port reads RAM only: page select is address bits 15:14, the word offset is bits 13:1, and bit 0 is always zero. The block arbitrates the parallel peripheral. A CPU request made during a LOAD is held with a wait signal until the LOAD ends, and that request stretches the LOAD. When a LOAD ends, the block gives a one-clock pulse that tells the peripheral side to put back the sound-generator address it held before the LOAD.

Top module: `dma_line_sched`

## Requirements
- R1: After reset the block is idle: `mem_req`, `exec_valid`, `cpu_wait`, `load_busy` and `psg_restore` are low, and every channel pointer is 0.
- R2: A rising edge of `hsync` seen on a clock where `slot_tick` is high makes the next slot period a dead slot: `mem_req` and `exec_valid` stay low for that whole slot.
- R3: The dead slot is followed by one fetch slot per active channel, in ascending channel order. During a fetch slot `mem_req` is high and `mem_addr` equals that channel's pointer, with bit 0 always 0.
- R4: A channel is active when `ch_en` is 1 and `ch_paused` is 0. This mask is captured on the `hsync` edge, and later changes to either input do not alter the slots of that line.
- R5: After each fetch, that channel's pointer advances by 2 and wraps modulo 2^16. Inactive channels keep their pointers.
- R6: The execute slots follow all fetch slots, in ascending channel order. During an execute slot `exec_valid` is high, `exec_ch` is the channel, and `exec_instr` is the word fetched for it in this line. A command that is not a LOAD lasts one slot.
- R7: A command whose bits 15:13 are 3'b001 is a LOAD, and its execute slot lasts 8 slot periods while `load_busy` is high.
- R8: While `load_busy` is high, a CPU peripheral request gives `cpu_wait`=1 and `cpu_grant`=0. Without a LOAD in progress, the request gets `cpu_grant`=1 and `cpu_wait`=0 at once.
- R9: A CPU request during a LOAD lengthens that LOAD once, by one slot period, or by two if `cpu_psg_wr` marks the request as a sound-generator register write.
- R10: `psg_restore` pulses high for exactly one clock at the end of each LOAD execute slot, so a line gives as many pulses as it has LOADs.
- R11: A pointer write (`sar_wr`, `sar_sel`, `sar_wdata`) takes effect at that channel's next fetch slot, and bit 0 of the written data is dropped.
- R12: After the last execute slot, or straight after the dead slot when no channel is active, the block stays idle until the next `hsync` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_tick | input | 1 | One-clock strobe marking each 1 us slot boundary |
| hsync | input | 1 | Horizontal sync level; its rising edge starts a line |
| ch_en | input | 3 | Per-channel enable |
| ch_paused | input | 3 | Per-channel pause state |
| sar_wr | input | 1 | Pointer write strobe |
| sar_sel | input | 2 | Channel selected for the pointer write |
| sar_wdata | input | 16 | Pointer write data (bit 0 dropped) |
| mem_rdata | input | 16 | RAM read data for the current fetch address |
| mem_req | output | 1 | Fetch slot in progress |
| mem_addr | output | 16 | Word-aligned RAM fetch address |
| mem_page | output | 2 | RAM page of the fetch address |
| exec_valid | output | 1 | Execute slot in progress |
| exec_ch | output | 2 | Channel being executed |
| exec_instr | output | 16 | Command being executed |
| load_busy | output | 1 | A LOAD holds the parallel peripheral |
| psg_restore | output | 1 | One-clock pulse at the end of a LOAD |
| cpu_ppi_req | input | 1 | CPU request for the parallel peripheral |
| cpu_psg_wr | input | 1 | The CPU request is a sound-generator register write |
| cpu_wait | output | 1 | CPU held off with wait states |
| cpu_grant | output | 1 | CPU request served |

## Verification
Random lines draw the enable and pause masks, so the bench sees lines with zero, one, two and three active channels. The single-channel lines show whether a fetch hands its word straight on to the execute slot that follows it. Lines whose enables are changed after the sync edge show whether the mask was captured at the edge or read live. CPU requests of both kinds are started at the first execute slot, over LOAD and non-LOAD commands and over runs of back-to-back LOADs; these tell a one-slot stretch from a two-slot stretch, and an immediate grant from a wait. Directed lines cover odd pointer writes, the wrap from FFFEh to 0000h, and a line with every channel off.

// File: rtl/dma_sched_pkg.sv
package dma_sched_pkg;
  typedef enum logic [1:0] {
    SLOT_IDLE  = 2'd0,
    SLOT_DEAD  = 2'd1,
    SLOT_FETCH = 2'd2,
    SLOT_EXEC  = 2'd3
  } slot_e;
endpackage

// File: rtl/dma_sar_bank.sv
module dma_sar_bank #(
  parameter int NCH = 3,
  parameter int AW  = 16,
  parameter int IW  = 16,
  parameter int CW  = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [CW-1:0]           wr_sel,
  input  logic [AW-1:0]           wr_data,
  input  logic                    fetch_done,
  input  logic [CW-1:0]           fetch_ch,
  input  logic [IW-1:0]           rdata,
  output logic [NCH-1:0][AW-1:0]  ptr,
  output logic [NCH-1:0][IW-1:0]  word
);
  localparam logic [AW-1:0] STEP = AW'(2);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam logic [CW-1:0] MY_ID = CW'(g);

    always_ff @(posedge clk) begin
      if (rst) begin
        ptr[g] <= '0;
      end else if (wr_en && wr_sel == MY_ID) begin
        ptr[g] <= {wr_data[AW-1:1], 1'b0};
      end else if (fetch_done && fetch_ch == MY_ID) begin
        ptr[g] <= ptr[g] + STEP;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        word[g] <= '0;
      end else if (fetch_done && fetch_ch == MY_ID) begin
        word[g] <= rdata;
      end
    end
  end
endmodule

// File: rtl/dma_slot_seq.sv
module dma_slot_seq
  import dma_sched_pkg::*;
#(
  parameter int NCH        = 3,
  parameter int CW         = 2,
  parameter int LOAD_SLOTS = 8,
  parameter int REM_W      = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           hs_rise,
  input  logic           tick,
  input  logic [NCH-1:0] act_in,
  input  logic [NCH-1:0] load_vec,
  input  logic           rd_load,
  input  logic [1:0]     ext_amt,
  output slot_e          st,
  output logic [CW-1:0]  cur,
  output logic           fetch_done,
  output logic           exec_start,
  output logic           restore
);
  localparam logic [REM_W-1:0] LOAD_REM = REM_W'(LOAD_SLOTS - 1);

  logic [NCH-1:0]   mask;
  logic [REM_W-1:0] rem;
  logic             more;
  logic [CW-1:0]    nxt;
  logic [CW-1:0]    first;
  logic             slot_end;
  logic             first_is_load;

  function automatic logic [CW-1:0] lowest(input logic [NCH-1:0] m);
    logic [CW-1:0] r;
    r = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (m[i]) r = CW'(i);
    end
    return r;
  endfunction

  always_comb begin
    more = 1'b0;
    nxt  = cur;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (mask[i] && (CW'(i) > cur)) begin
        more = 1'b1;
        nxt  = CW'(i);
      end
    end
  end

  assign first         = lowest(mask);
  assign first_is_load = (first == cur) ? rd_load : load_vec[first];
  assign slot_end      = tick && (rem == '0) && (ext_amt == 2'd0);
  assign fetch_done    = !hs_rise && (st == SLOT_FETCH) && tick;
  assign exec_start    = !hs_rise && tick &&
                         (((st == SLOT_FETCH) && !more) ||
                          ((st == SLOT_EXEC) && (rem == '0) && (ext_amt == 2'd0) && more));

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= SLOT_IDLE;
      cur     <= '0;
      mask    <= '0;
      rem     <= '0;
      restore <= 1'b0;
    end else begin
      restore <= 1'b0;
      if (hs_rise) begin
        st   <= SLOT_DEAD;
        mask <= act_in;
        rem  <= '0;
      end else begin
        unique case (st)
          SLOT_DEAD: begin
            if (tick) begin
              if (mask != '0) begin
                st  <= SLOT_FETCH;
                cur <= first;
              end else begin
                st <= SLOT_IDLE;
              end
            end
          end
          SLOT_FETCH: begin
            if (tick) begin
              if (more) begin
                cur <= nxt;
              end else begin
                st  <= SLOT_EXEC;
                cur <= first;
                rem <= first_is_load ? LOAD_REM : '0;
              end
            end
          end
          SLOT_EXEC: begin
            if (slot_end) begin
              restore <= load_vec[cur];
              if (more) begin
                cur <= nxt;
                rem <= load_vec[nxt] ? LOAD_REM : '0;
              end else begin
                st <= SLOT_IDLE;
              end
            end else begin
              rem <= rem + REM_W'(ext_amt) - REM_W'(tick);
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/dma_ppi_arb.sv
module dma_ppi_arb (
  input  logic       clk,
  input  logic       rst,
  input  logic       load_busy,
  input  logic       exec_start,
  input  logic       cpu_req,
  input  logic       cpu_psg,
  output logic       cpu_wait,
  output logic       cpu_grant,
  output logic [1:0] ext_amt
);
  logic ext_done;

  assign cpu_wait  = cpu_req && load_busy;
  assign cpu_grant = cpu_req && !load_busy;
  assign ext_amt   = (cpu_wait && !ext_done) ? (cpu_psg ? 2'd2 : 2'd1) : 2'd0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_done <= 1'b0;
    end else if (exec_start) begin
      ext_done <= 1'b0;
    end else if (ext_amt != 2'd0) begin
      ext_done <= 1'b1;
    end
  end
endmodule

// File: rtl/dma_line_sched.sv
module dma_line_sched
  import dma_sched_pkg::*;
#(
  parameter int             NCH        = 3,
  parameter int             AW         = 16,
  parameter int             IW         = 16,
  parameter int             OP_W       = 3,
  parameter logic [OP_W-1:0] LOAD_OP   = 3'b001,
  parameter int             LOAD_SLOTS = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     slot_tick,
  input  logic                     hsync,
  input  logic [NCH-1:0]           ch_en,
  input  logic [NCH-1:0]           ch_paused,
  input  logic                     sar_wr,
  input  logic [$clog2(NCH)-1:0]   sar_sel,
  input  logic [AW-1:0]            sar_wdata,
  input  logic [IW-1:0]            mem_rdata,
  output logic                     mem_req,
  output logic [AW-1:0]            mem_addr,
  output logic [1:0]               mem_page,
  output logic                     exec_valid,
  output logic [$clog2(NCH)-1:0]   exec_ch,
  output logic [IW-1:0]            exec_instr,
  output logic                     load_busy,
  output logic                     psg_restore,
  input  logic                     cpu_ppi_req,
  input  logic                     cpu_psg_wr,
  output logic                     cpu_wait,
  output logic                     cpu_grant
);
  localparam int CW    = $clog2(NCH);
  localparam int REM_W = $clog2(LOAD_SLOTS + 3);

  logic                   hs_q;
  logic                   hs_rise;
  slot_e                  st;
  logic [CW-1:0]          cur;
  logic                   fetch_done;
  logic                   exec_start;
  logic [1:0]             ext_amt;
  logic [NCH-1:0][AW-1:0] ptr;
  logic [NCH-1:0][IW-1:0] word;
  logic [NCH-1:0]         load_vec;
  logic                   rd_load;

  always_ff @(posedge clk) begin
    if (rst) hs_q <= 1'b0;
    else     hs_q <= hsync;
  end
  assign hs_rise = hsync && !hs_q;

  for (genvar g = 0; g < NCH; g++) begin : g_dec
    assign load_vec[g] = (word[g][IW-1 -: OP_W] == LOAD_OP);
  end
  assign rd_load = (mem_rdata[IW-1 -: OP_W] == LOAD_OP);

  dma_sar_bank #(.NCH(NCH), .AW(AW), .IW(IW), .CW(CW)) u_bank (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (sar_wr),
    .wr_sel     (sar_sel),
    .wr_data    (sar_wdata),
    .fetch_done (fetch_done),
    .fetch_ch   (cur),
    .rdata      (mem_rdata),
    .ptr        (ptr),
    .word       (word)
  );

  dma_slot_seq #(.NCH(NCH), .CW(CW), .LOAD_SLOTS(LOAD_SLOTS), .REM_W(REM_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .hs_rise    (hs_rise),
    .tick       (slot_tick),
    .act_in     (ch_en & ~ch_paused),
    .load_vec   (load_vec),
    .rd_load    (rd_load),
    .ext_amt    (ext_amt),
    .st         (st),
    .cur        (cur),
    .fetch_done (fetch_done),
    .exec_start (exec_start),
    .restore    (psg_restore)
  );

  dma_ppi_arb u_arb (
    .clk        (clk),
    .rst        (rst),
    .load_busy  (load_busy),
    .exec_start (exec_start),
    .cpu_req    (cpu_ppi_req),
    .cpu_psg    (cpu_psg_wr),
    .cpu_wait   (cpu_wait),
    .cpu_grant  (cpu_grant),
    .ext_amt    (ext_amt)
  );

  assign mem_req    = (st == SLOT_FETCH);
  assign mem_addr   = ptr[cur];
  assign mem_page   = mem_addr[AW-1 -: 2];
  assign exec_valid = (st == SLOT_EXEC);
  assign exec_ch    = cur;
  assign exec_instr = word[cur];
  assign load_busy  = exec_valid && load_vec[cur];
endmodule

// File: rtl/dma_sched_chk.sv
module dma_sched_chk #(
  parameter int              AW      = 16,
  parameter int              IW      = 16,
  parameter int              OP_W    = 3,
  parameter logic [OP_W-1:0] LOAD_OP = 3'b001
) (
  input logic          clk,
  input logic          rst,
  input logic          hsync,
  input logic          slot_tick,
  input logic          mem_req,
  input logic [AW-1:0] mem_addr,
  input logic          exec_valid,
  input logic [IW-1:0] exec_instr,
  input logic          psg_restore,
  input logic          cpu_wait,
  input logic          cpu_grant
);
  p_even_fetch_r3: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[0] == 1'b0));

  p_dead_slot_r2: assert property (@(posedge clk) disable iff (rst)
    ($rose(hsync) && slot_tick) |=> (!mem_req && !exec_valid));

  p_no_overlap_r6: assert property (@(posedge clk) disable iff (rst)
    !(mem_req && exec_valid));

  p_wait_in_load_r8: assert property (@(posedge clk) disable iff (rst)
    cpu_wait |-> (exec_valid && exec_instr[IW-1 -: OP_W] == LOAD_OP && !cpu_grant));

  p_restore_single_r10: assert property (@(posedge clk) disable iff (rst)
    psg_restore |=> !psg_restore);
endmodule

bind dma_line_sched dma_sched_chk #(.AW(AW), .IW(IW), .OP_W(OP_W), .LOAD_OP(LOAD_OP)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .hsync       (hsync),
  .slot_tick   (slot_tick),
  .mem_req     (mem_req),
  .mem_addr    (mem_addr),
  .exec_valid  (exec_valid),
  .exec_instr  (exec_instr),
  .psg_restore (psg_restore),
  .cpu_wait    (cpu_wait),
  .cpu_grant   (cpu_grant)
);

// File: tb/dma_line_sched_tb.sv
`timescale 1ns/1ps
module dma_line_sched_tb;
  localparam int TDIV = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hsync = 1'b0;
  logic [2:0] ch_en = '0, ch_paused = '0;
  logic sar_wr = 1'b0;
  logic [1:0] sar_sel = '0;
  logic [15:0] sar_wdata = '0;
  logic [15:0] mem_rdata;
  logic mem_req, exec_valid, load_busy, psg_restore, cpu_wait, cpu_grant;
  logic [15:0] mem_addr, exec_instr;
  logic [1:0] mem_page, exec_ch;
  logic cpu_ppi_req = 1'b0, cpu_psg_wr = 1'b0;
  logic [1:0] phase = '0;
  logic slot_tick;

  int checks = 0, errors = 0, restores = 0;
  bit done = 0;
  logic [15:0] sar_exp [3];

  always #4 clk = ~clk;
  always @(posedge clk) phase <= phase + 2'd1;
  assign slot_tick = (phase == 2'(TDIV - 1));
  always @(posedge clk) if (!rst && psg_restore) restores <= restores + 1;

  function automatic logic [15:0] memf(input logic [15:0] a);
    logic [14:0] h;
    h = a[15:1];
    return {(((h ^ (h >> 3)) % 3) == 0) ? 3'b001 : 3'b010, h[12:0]};
  endfunction
  assign mem_rdata = memf(mem_addr);

  dma_line_sched u_dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_sar(input int ch, input logic [15:0] d);
    @(negedge clk);
    sar_wr = 1'b1; sar_sel = 2'(ch); sar_wdata = d;
    @(negedge clk);
    sar_wr = 1'b0;
    sar_exp[ch] = {d[15:1], 1'b0};
  endtask

  task automatic slot_wait();
    repeat (TDIV) @(negedge clk);
  endtask

  // mode: 0 no CPU, 1 plain access, 2 sound-generator write
  task automatic do_line(input logic [2:0] en, input logic [2:0] pz, input int mode, input bit scramble);
    logic [2:0] act;
    logic [15:0] w [3];
    bit ld [3];
    bit cpu_on, first;
    int nload, r0, len;
    act = en & ~pz;
    nload = 0;
    for (int c = 0; c < 3; c++) begin
      w[c] = memf(sar_exp[c]);
      ld[c] = (w[c][15:13] == 3'b001);
      if (act[c] && ld[c]) nload++;
    end
    @(negedge clk);
    while (phase != 2'(TDIV - 1)) @(negedge clk);
    hsync = 1'b1; ch_en = en; ch_paused = pz;
    @(negedge clk);
    r0 = restores;
    chk(!mem_req && !exec_valid, "R2 dead slot", {mem_req, exec_valid}, 0);
    hsync = 1'b0;
    if (scramble) begin ch_en = ~en; ch_paused = ~pz; end
    for (int c = 0; c < 3; c++) begin
      if (act[c]) begin
        slot_wait();
        chk(mem_req && !exec_valid, "R4 fetch slot present", {mem_req, exec_valid}, 2);
        chk(mem_addr == sar_exp[c], "R3 fetch address", mem_addr, sar_exp[c]);
        chk(mem_page == sar_exp[c][15:14], "R3 page", mem_page, sar_exp[c][15:14]);
        sar_exp[c] = sar_exp[c] + 16'd2;
      end
    end
    cpu_on = 1'b0; first = 1'b1;
    for (int c = 0; c < 3; c++) begin
      if (act[c]) begin
        slot_wait();
        if (first && mode != 0) begin
          cpu_ppi_req = 1'b1; cpu_psg_wr = (mode == 2); cpu_on = 1'b1;
          #1;
        end
        first = 1'b0;
        len = ld[c] ? 8 : 1;
        if (cpu_on && ld[c]) begin
          len += (mode == 2) ? 2 : 1;
          chk(cpu_wait && !cpu_grant, "R8 wait during LOAD", {cpu_wait, cpu_grant}, 2);
        end else if (cpu_on) begin
          chk(cpu_grant && !cpu_wait, "R8 grant outside LOAD", {cpu_wait, cpu_grant}, 1);
          cpu_ppi_req = 1'b0; cpu_on = 1'b0;
        end
        for (int s = 0; s < len; s++) begin
          if (s > 0) slot_wait();
          chk(exec_valid && !mem_req && exec_ch == 2'(c), "R6 exec slot", {exec_valid, mem_req, exec_ch}, {2'b10, 2'(c)});
          chk(exec_instr == w[c], "R6 exec word", exec_instr, w[c]);
          if (ld[c]) chk(load_busy, "R7 LOAD busy", load_busy, 1);
        end
      end
    end
    slot_wait();
    chk(!exec_valid && !mem_req && !load_busy, "R12 idle after line (R9 length)", {exec_valid, mem_req, load_busy}, 0);
    if (cpu_on) begin
      #1;
      chk(cpu_grant && !cpu_wait, "R8 grant after LOAD", {cpu_wait, cpu_grant}, 1);
      cpu_ppi_req = 1'b0;
    end
    repeat (2) @(negedge clk);
    chk(restores - r0 == nload, "R10 restore pulses", restores - r0, nload);
    slot_wait();
    chk(!exec_valid && !mem_req, "R12 still idle", {exec_valid, mem_req}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] a;
    void'($urandom(32'd1357));
    for (int c = 0; c < 3; c++) sar_exp[c] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!mem_req && !exec_valid && !cpu_wait && !load_busy && !psg_restore, "R1 reset idle",
        {mem_req, exec_valid, cpu_wait, load_busy, psg_restore}, 0);
    do_line(3'b111, 3'b000, 0, 0);                         // R1 pointers from 0, R5
    do_line(3'b000, 3'b000, 0, 0);                         // R12 nothing active
    do_line(3'b111, 3'b111, 0, 0);                         // R4 all paused
    wr_sar(1, 16'h4567);                                   // R11 odd data
    do_line(3'b010, 3'b000, 0, 0);
    wr_sar(2, 16'hFFFE);                                   // R5 wrap
    do_line(3'b100, 3'b000, 0, 0);
    chk(sar_exp[2] == 16'h0000, "R5 wrap model", sar_exp[2], 0);
    do_line(3'b100, 3'b000, 0, 0);
    a = 16'h1000;
    while (memf(a)[15:13] != 3'b001) a = a + 16'd2;
    wr_sar(0, a);
    do_line(3'b001, 3'b000, 2, 0);                         // R9 two-slot stretch
    wr_sar(0, a);
    do_line(3'b011, 3'b000, 1, 1);                         // R9 one-slot, R4 scramble
    wr_sar(0, a);
    do_line(3'b001, 3'b000, 0, 0);                         // R7 plain LOAD
    for (int i = 0; i < 50; i++) begin
      if ($urandom % 4 == 0) wr_sar(int'($urandom % 3), 16'($urandom));
      do_line(3'($urandom), 3'($urandom % 8 == 0 ? $urandom : 0), int'($urandom % 3), bit'($urandom % 4 == 0));
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule